// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers eight single-cycle interrupt events into two 4-bit flag banks. Each bank has a matching 4-bit enable bank, and the block drives a single interrupt request line toward a CPU core. Bank 0 records four periodic base-timer ticks of different intervals. Bank 1 records a timer overflow, the overflow of one selected pulse-counter channel, the end of an SPI shift and a comparator crossing. The comparator crossing is detected on a synchronized digital level that is high while the positive input sits above the negative one.

Flags are sticky. An event always sets its flag, whatever the enable bits hold. Only software clears a flag, by writing 0 into its bit position. The enables decide only which set flags drive the request line. Software reaches the four registers through a simple write port and a registered read port.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, every enable bit and every flag bit is cleared to 0. `irq_req` and `rd_data` are 0 after that edge.
- R2: A 1 on `bt_evt[i]` sets bit i of flag bank 0 at that clock edge.
- R3: The bit positions of flag bank 1 are: bit 0 is the timer overflow (`tmr_ovf`), bit 1 is the pulse-counter overflow, bit 2 is SPI done (`spi_done`), and bit 3 is the comparator crossing.
- R4: A write to a flag bank (`wr_addr` 2 for bank 0, 3 for bank 1) clears each bit where `wr_data` holds 0. A bit where `wr_data` holds 1 keeps its value.
- R5: When an event and a software clear hit the same flag bit in the same cycle, the flag ends up set.
- R6: A flag bit that sees no event and no clearing write keeps its value. Reading a register never changes it.
- R7: Enable bits have no effect on flag setting. A flag sets even when its enable bit is 0.
- R8: Only `pcnt_ovf[PC_TRIG_CH]` (channel 1 by default) sets bank-1 bit 1. Overflows on all other channels are ignored.
- R9: The comparator flag sets only on a 0-to-1 change of `cmp_above` seen after reset. A level that is high from reset, or that stays high, never sets it.
- R10: `irq_req` is 1 in the cycle after an edge exactly when some flag bit and its enable bit were both 1 before that edge. In other words, the request is registered, with one cycle of latency.
- R11: `wr_en` with `wr_addr` 0 or 1 loads enable bank 0 or 1 from `wr_data`. After each edge, `rd_data` shows the pre-edge value of the register chosen by `rd_addr`: 0 is enable 0, 1 is enable 1, 2 is flag 0, 3 is flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 4 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 4 | Registered read data |
| bt_evt | input | 4 | Base-timer tick pulses, one per interval |
| tmr_ovf | input | 1 | Timer-counter overflow pulse |
| pcnt_ovf | input | PC_CH | Pulse-counter overflow pulses, one per channel |
| spi_done | input | 1 | SPI shift-complete pulse |
| cmp_above | input | 1 | Synchronized comparator level, high when the positive input is above the negative input |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: a 4-bit register width, four pulse-counter channels and channel 1 as the trigger. With these values the ignored channels 0, 2 and 3 can be driven on both sides of the trigger, so a wrong channel select shows up as a stray flag. The comparator is held high through reset so that the arming rule is tested from the very first cycle. Random clears are mixed with random event pulses, which makes same-cycle clear-and-set collisions frequent.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    A_EN0  = 2'd0,
    A_EN1  = 2'd1,
    A_FLG0 = 2'd2,
    A_FLG1 = 2'd3
  } irqc_addr_e;

  localparam int NUM_BANKS = 2;
  localparam int B1_TMR    = 0;
  localparam int B1_PCNT   = 1;
  localparam int B1_SPI    = 2;
  localparam int B1_CMP    = 3;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] flags
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic clr_bit;
      assign clr_bit = clr_we && !clr_data[i];

      always_ff @(posedge clk) begin
        if (rst)            flags[i] <= 1'b0;
        else if (evt[i])    flags[i] <= 1'b1;
        else if (clr_bit)   flags[i] <= 1'b0;
      end

      // R2, R5, R7: an event always sets the flag
      p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> flags[i]);
      // R4: a write of 0 without an event clears
      p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !clr_data[i] && !evt[i]) |=> !flags[i]);
      // R6: no event and no clearing write leaves the bit alone
      p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!evt[i] && !(clr_we && !clr_data[i])) |=> $stable(flags[i]));
    end
  endgenerate
endmodule

// File: rtl/irqc_cmp_edge.sv
module irqc_cmp_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  // Reset to 1: a level already high at reset is not a crossing.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= lvl;
  end

  assign rise = lvl && !prev_q;

  // R9: a crossing is reported only while the level is high and only once
  p_rise_single_r9: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
  p_rise_level_r9: assert property (@(posedge clk) disable iff (rst)
    rise |-> lvl);
endmodule

// File: rtl/irqc_req_merge.sv
module irqc_req_merge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         req
);
  logic [N-1:0] hits;
  assign hits = flags & enables;

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= |hits;
  end

  // R10: request follows pending enabled flags with one cycle of latency
  p_req_follow_r10: assert property (@(posedge clk) disable iff (rst)
    ($countones(flags & enables) != 0) |=> req);
  p_req_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ((flags & enables) == '0) |=> !req);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int DATA_W     = 4,
  parameter int PC_CH      = 4,
  parameter int PC_TRIG_CH = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] bt_evt,
  input  logic              tmr_ovf,
  input  logic [PC_CH-1:0]  pcnt_ovf,
  input  logic              spi_done,
  input  logic              cmp_above,
  output logic              irq_req
);
  import irqc_pkg::*;

  localparam int NB     = NUM_BANKS;
  localparam int TOTAL  = NB * DATA_W;

  logic [DATA_W-1:0] en_q     [NB];
  logic [DATA_W-1:0] flag_q   [NB];
  logic [DATA_W-1:0] bank_evt [NB];
  logic [NB-1:0]     clr_we;
  logic              cmp_rise;
  logic [TOTAL-1:0]  flag_flat;
  logic [TOTAL-1:0]  en_flat;

  irqc_cmp_edge u_cmp (
    .clk  (clk),
    .rst  (rst),
    .lvl  (cmp_above),
    .rise (cmp_rise)
  );

  always_comb begin
    bank_evt[0]          = bt_evt;
    bank_evt[1]          = '0;
    bank_evt[1][B1_TMR]  = tmr_ovf;
    bank_evt[1][B1_PCNT] = pcnt_ovf[PC_TRIG_CH];
    bank_evt[1][B1_SPI]  = spi_done;
    bank_evt[1][B1_CMP]  = cmp_rise;
  end

  assign clr_we[0] = wr_en && (wr_addr == A_FLG0);
  assign clr_we[1] = wr_en && (wr_addr == A_FLG1);

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      irqc_flag_bank #(.W(DATA_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .evt      (bank_evt[b]),
        .clr_we   (clr_we[b]),
        .clr_data (wr_data),
        .flags    (flag_q[b])
      );
      assign flag_flat[b*DATA_W +: DATA_W] = flag_q[b];
      assign en_flat[b*DATA_W +: DATA_W]   = en_q[b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q[0] <= '0;
      en_q[1] <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_EN0) en_q[0] <= wr_data;
      if (wr_addr == A_EN1) en_q[1] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (irqc_addr_e'(rd_addr))
        A_EN0:   rd_data <= en_q[0];
        A_EN1:   rd_data <= en_q[1];
        A_FLG0:  rd_data <= flag_q[0];
        default: rd_data <= flag_q[1];
      endcase
    end
  end

  irqc_req_merge #(.N(TOTAL)) u_req (
    .clk     (clk),
    .rst     (rst),
    .flags   (flag_flat),
    .enables (en_flat),
    .req     (irq_req)
  );

  // R1: reset clears the visible outputs
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (irq_req == 1'b0 && rd_data == '0));
  // R8: non-trigger pulse channels never set the pulse flag
  p_pcnt_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (!pcnt_ovf[PC_TRIG_CH] && !flag_q[1][B1_PCNT]) |=> !flag_q[1][B1_PCNT]);
  // R7: a disabled event still sets its flag
  p_en_no_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (tmr_ovf && !en_q[1][B1_TMR]) |=> flag_q[1][B1_TMR]);
endmodule

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int PCH = 4;
  localparam int TRIG = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] bt_evt = '0;
  logic tmr_ovf = 1'b0;
  logic [PCH-1:0] pcnt_ovf = '0;
  logic spi_done = 1'b0;
  logic cmp_above = 1'b1;
  logic irq_req;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  // bench model
  logic [W-1:0] m_en0 = '0, m_en1 = '0, m_f0 = '0, m_f1 = '0;
  logic m_prev = 1'b1;
  logic [W-1:0] m_rd = '0;
  logic m_irq = 1'b0;

  irq_flag_ctrl #(.DATA_W(W), .PC_CH(PCH), .PC_TRIG_CH(TRIG)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bt_evt(bt_evt), .tmr_ovf(tmr_ovf),
    .pcnt_ovf(pcnt_ovf), .spi_done(spi_done), .cmp_above(cmp_above),
    .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] nxt_flag(logic [W-1:0] cur, logic [W-1:0] ev,
                                            logic clr, logic [W-1:0] d);
    return ev | (clr ? (cur & d) : cur);
  endfunction

  function automatic logic [W-1:0] pick(logic [1:0] a, logic [W-1:0] e0,
      logic [W-1:0] e1, logic [W-1:0] f0, logic [W-1:0] f1);
    case (a)
      2'd0: return e0;
      2'd1: return e1;
      2'd2: return f0;
      default: return f1;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(string tag);
    logic [W-1:0] ev1;
    logic crise;
    @(posedge clk);
    cyc++;
    if (rst) begin
      m_en0 = '0; m_en1 = '0; m_f0 = '0; m_f1 = '0;
      m_prev = 1'b1; m_rd = '0; m_irq = 1'b0;
    end else begin
      crise = cmp_above && !m_prev;
      ev1 = {crise, spi_done, pcnt_ovf[TRIG], tmr_ovf};
      m_rd  = pick(rd_addr, m_en0, m_en1, m_f0, m_f1);
      m_irq = |({m_f1, m_f0} & {m_en1, m_en0});
      m_f0 = nxt_flag(m_f0, bt_evt, wr_en && wr_addr == 2'd2, wr_data);
      m_f1 = nxt_flag(m_f1, ev1, wr_en && wr_addr == 2'd3, wr_data);
      if (wr_en && wr_addr == 2'd0) m_en0 = wr_data;
      if (wr_en && wr_addr == 2'd1) m_en1 = wr_data;
      m_prev = cmp_above;
    end
    @(negedge clk);
    check({tag, " R11 rd_data"}, 32'(rd_data), 32'(m_rd));
    check({tag, " R10 irq_req"}, 32'(irq_req), 32'(m_irq));
    wr_en = 1'b0; bt_evt = '0; tmr_ovf = 1'b0; pcnt_ovf = '0; spi_done = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d, string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(tag);
  endtask

  task automatic rd(logic [1:0] a, logic [W-1:0] exp, string tag);
    rd_addr = a;
    step(tag);
    check(tag, 32'(rd_data), 32'(exp));
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    rst = 1'b1;
    for (int k = 0; k < 3; k++) step("reset");
    rst = 1'b0;
    check("R1 irq after reset", 32'(irq_req), 32'd0);
    for (int a = 0; a < 4; a++) rd(2'(a), '0, "R1 register reset");
    // comparator high since reset: no flag
    rd(2'd3, 4'h0, "R9 high from reset");
    rd(2'd3, 4'h0, "R9 high from reset hold");

    bt_evt = 4'b0101; step("R2 evt");
    rd(2'd2, 4'h5, "R2/R7 flag0 with enables off");
    check("R7 no irq when disabled", 32'(irq_req), 32'd0);

    wr(2'd2, 4'b1110, "R4 clear bit0");
    rd(2'd2, 4'h4, "R4 write0 clears");
    wr(2'd2, 4'b1111, "R4 write1");
    rd(2'd2, 4'h4, "R4 write1 keeps");

    bt_evt = 4'b0100; wr(2'd2, 4'b0000, "R5 collide");
    rd(2'd2, 4'h4, "R5 event wins");

    tmr_ovf = 1'b1; step("R3 tmr");
    rd(2'd3, 4'h1, "R3 timer bit0");
    spi_done = 1'b1; step("R3 spi");
    rd(2'd3, 4'h5, "R3 spi bit2");

    pcnt_ovf = 4'b1101; step("R8 other channels");
    rd(2'd3, 4'h5, "R8 other channels ignored");
    pcnt_ovf = 4'b0010; step("R8 trig channel");
    rd(2'd3, 4'h7, "R3/R8 pulse bit1");

    cmp_above = 1'b0; step("R9 low");
    cmp_above = 1'b1; step("R9 rise");
    rd(2'd3, 4'hF, "R9 comparator bit3");
    wr(2'd3, 4'h0, "R9 clear");
    rd(2'd3, 4'h0, "R9 steady high no reset");
    rd(2'd3, 4'h0, "R9 steady high hold");

    wr(2'd0, 4'b0100, "R11 en0 write");
    rd(2'd0, 4'h4, "R11 en0 readback");
    check("R10 irq asserted", 32'(irq_req), 32'd1);
    for (int k = 0; k < 4; k++) rd(2'd2, 4'h4, "R6 flag sticky on read");
    wr(2'd2, 4'h0, "R10 clear");
    check("R10 irq one cycle later", 32'(irq_req), 32'd1);
    step("R10 drop");
    check("R10 irq drops", 32'(irq_req), 32'd0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      rd_addr = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1;
        wr_addr = 2'($urandom_range(0, 3));
        wr_data = 4'($urandom);
      end
      if ($urandom_range(0, 5) == 0) bt_evt = 4'($urandom);
      tmr_ovf = ($urandom_range(0, 9) == 0);
      spi_done = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 6) == 0) pcnt_ovf = 4'($urandom);
      if ($urandom_range(0, 7) == 0) cmp_above = ~cmp_above;
      step("R2/R4/R5/R8/R9 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule